// File: doc/BRIEF.md
# Interrupt Flag and Vector Controller

This block holds the interrupt request state for a small 8-bit processor core. Three core sources (port change, external pin, timer-0 overflow) and two peripheral groups of eight sources each have a pending flag and an enable bit. A peripheral-group enable gates both peripheral groups, and a global enable gates everything. Every flag latches its event whatever the mask state. Software clears a flag only by writing the register that holds it.

The core raises `insn_boundary` in each clock where an instruction completes. When a request is pending at a boundary, the block pulses `take_irq` and `push_ret` for one clock and presents the fixed vector 0x0004 on `vector_pc`. On the same edge it clears the global enable. The core pulses `retfie` on return from the service routine, and that sets the global enable again. A flag that is still set then raises a fresh request. All handshake pins are plain strobes with no back-pressure. The core must accept a `take_irq` pulse in the cycle it appears.

A write-through register bus reads and writes all state with no read side effects. `reg_rdata` is combinational from `reg_addr`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: An event pulse sets its flag on the next clock edge, whether or not its own enable, the group enable or the global enable is set. If software writes 0 to that flag in the same cycle, the event still wins and the flag ends up set.
- R2: Reset clears every flag, every enable, the peripheral-group enable and the global enable. All five registers then read 0 and `take_irq` is low.
- R3: A take drives `take_irq` and `push_ret` high together for exactly one clock, with `vector_pc` equal to 0x0004. The global enable reads 0 from that cycle on.
- R4: A `retfie` pulse while the global enable is 0 sets it on the next edge.
- R5: When a register write clears the global enable, no take happens on that edge even if a request is pending. The flag stays set, and the request is taken after the global enable is written back to 1.
- R6: A flag is never cleared except by a write to its register. If a flag is still set and enabled when the global enable returns to 1, another take follows.
- R7: The request is the global enable ANDed with the OR of two terms. The first term is any core flag whose enable is set. The second term is the peripheral-group enable ANDed with any peripheral flag whose enable is set.
- R8: Register map, with the core index order 0 = port change, 1 = external pin, 2 = timer-0:
  - Address 0 is the core register. Bit 7 is the global enable, bit 6 the peripheral-group enable, bits 5:3 the core enables and bits 2:0 the core flags.
  - Address 1 holds the group-0 flags and address 2 the group-0 enables.
  - Address 3 holds the group-1 flags and address 4 the group-1 enables.
  - Other addresses read 0 and ignore writes.
- R9: Suppose an event is sampled at clock edge k, its enables and the global enable are set, `insn_boundary` is high and no take is under way. Then the flag reads 1 after edge k and `take_irq` is high after edge k+1.
- R10: `take_irq` is never asserted after an edge where `insn_boundary` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_evt | input | 3 | Core source event pulses (0 port change, 1 external pin, 2 timer-0) |
| per0_evt | input | DATA_W | Peripheral group-0 event pulses |
| per1_evt | input | DATA_W | Peripheral group-1 event pulses |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| insn_boundary | input | 1 | High in a clock where an instruction completes |
| retfie | input | 1 | Return-from-interrupt strobe |
| take_irq | output | 1 | One-clock interrupt-taken strobe |
| push_ret | output | 1 | One-clock command to push the return address |
| vector_pc | output | PC_W | Interrupt vector address (0x0004) |

## Verification
A flag register that drops a set or clears without a write shows on the bus at the next read. It also shows as a missing or extra `take_irq`, no more than two edges after the event. A global-enable register that is not cleared on entry shows as `take_irq` held longer than one clock, or as a second take with no `retfie` in between. A failed suppression shows as a take in the very cycle after the clearing write. The bench compares all outputs and the addressed register against a spec-level model on every clock, so any divergence is caught in the cycle it appears.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int CORE_N   = 3;
  localparam int GIE_BIT  = 7;
  localparam int PEIE_BIT = 6;
  localparam int GROUPS   = 2;
  localparam logic [2:0] A_CORE     = 3'd0;
  localparam logic [2:0] A_PER_BASE = 3'd1;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         flag_we,
  input  logic [W-1:0] flag_wd,
  input  logic         en_we,
  input  logic [W-1:0] en_wd,
  output logic [W-1:0] flags,
  output logic [W-1:0] enables,
  output logic         hit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags   <= '0;
      enables <= '0;
    end else begin
      // hardware set has priority over a software clear
      flags <= (flag_we ? flag_wd : flags) | evt;
      if (en_we) enables <= en_wd;
    end
  end

  assign hit = |(flags & enables);

  // R1
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));
  // R6
  no_silent_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/irq_take_ctrl.sv
module irq_take_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic core_hit,
  input  logic per_hit,
  input  logic ctl_we,
  input  logic gie_wd,
  input  logic peie_wd,
  input  logic insn_boundary,
  input  logic retfie,
  output logic gie,
  output logic peie,
  output logic take
);
  logic req, suppress, take_d;

  assign req      = gie & (core_hit | (peie & per_hit));
  assign suppress = ctl_we & ~gie_wd;
  assign take_d   = insn_boundary & req & ~suppress & ~take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie  <= 1'b0;
      peie <= 1'b0;
      take <= 1'b0;
    end else begin
      take <= take_d;
      if (take_d)      gie <= 1'b0;
      else if (retfie) gie <= 1'b1;
      else if (ctl_we) gie <= gie_wd;
      if (ctl_we) peie <= peie_wd;
    end
  end

  // R3
  take_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !gie);
  // R3
  take_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  // R4
  retfie_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retfie && !gie) |=> gie);
  // R5
  gie_clear_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !gie_wd) |=> !take);
  // R10
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_boundary |=> !take);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int          DATA_W = 8,
  parameter int          PC_W   = 13,
  parameter logic [12:0] VECTOR = 13'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CORE_N-1:0] core_evt,
  input  logic [DATA_W-1:0] per0_evt,
  input  logic [DATA_W-1:0] per1_evt,
  input  logic [2:0]        reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              insn_boundary,
  input  logic              retfie,
  output logic              take_irq,
  output logic              push_ret,
  output logic [PC_W-1:0]   vector_pc
);
  localparam int EN_LO = CORE_N;

  logic              core_we;
  logic [CORE_N-1:0] core_flags, core_ens;
  logic              core_hit;
  logic              gie, peie, take;

  logic [GROUPS-1:0][DATA_W-1:0] per_evt_a, per_flags, per_ens;
  logic [GROUPS-1:0]             per_hit_v;

  assign core_we   = reg_we && (reg_addr == A_CORE);
  assign per_evt_a = {per1_evt, per0_evt};

  irq_flag_bank #(.W(CORE_N)) u_core_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (core_evt),
    .flag_we (core_we),
    .flag_wd (reg_wdata[CORE_N-1:0]),
    .en_we   (core_we),
    .en_wd   (reg_wdata[EN_LO +: CORE_N]),
    .flags   (core_flags),
    .enables (core_ens),
    .hit     (core_hit)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_per
    localparam logic [2:0] FA = A_PER_BASE + 3'(2 * g);
    localparam logic [2:0] EA = A_PER_BASE + 3'(2 * g + 1);
    irq_flag_bank #(.W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (per_evt_a[g]),
      .flag_we (reg_we && (reg_addr == FA)),
      .flag_wd (reg_wdata),
      .en_we   (reg_we && (reg_addr == EA)),
      .en_wd   (reg_wdata),
      .flags   (per_flags[g]),
      .enables (per_ens[g]),
      .hit     (per_hit_v[g])
    );
  end

  irq_take_ctrl u_take (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_hit      (core_hit),
    .per_hit       (|per_hit_v),
    .ctl_we        (core_we),
    .gie_wd        (reg_wdata[GIE_BIT]),
    .peie_wd       (reg_wdata[PEIE_BIT]),
    .insn_boundary (insn_boundary),
    .retfie        (retfie),
    .gie           (gie),
    .peie          (peie),
    .take          (take)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata = DATA_W'({gie, peie, core_ens, core_flags});
      3'd1: reg_rdata = per_flags[0];
      3'd2: reg_rdata = per_ens[0];
      3'd3: reg_rdata = per_flags[1];
      3'd4: reg_rdata = per_ens[1];
      default: reg_rdata = '0;
    endcase
  end

  assign take_irq  = take;
  assign push_ret  = take;
  assign vector_pc = PC_W'(VECTOR);

  // R3
  push_with_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ret == take_irq);
  // R3
  vector_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (vector_pc == PC_W'(13'h0004)));
endmodule

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] core_evt = '0;
  logic [7:0] per0_evt = '0, per1_evt = '0;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       insn_boundary = 1'b0, retfie = 1'b0;
  logic       take_irq, push_ret;
  logic [12:0] vector_pc;

  int checks = 0, fails = 0;
  bit done = 0;

  // spec model
  logic [2:0] m_cf, m_ce;
  logic       m_gie, m_peie, m_take;
  logic [7:0] m_pf0, m_pe0, m_pf1, m_pe1;

  always #2 clk = ~clk;

  irq_vector_ctrl dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return {m_gie, m_peie, m_ce, m_cf};
      3'd1: return m_pf0;
      3'd2: return m_pe0;
      3'd3: return m_pf1;
      3'd4: return m_pe1;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_reset();
    m_cf = '0; m_ce = '0; m_gie = 0; m_peie = 0; m_take = 0;
    m_pf0 = '0; m_pe0 = '0; m_pf1 = '0; m_pe1 = '0;
  endtask

  task automatic step(string tag);
    logic req, clr, tk;
    logic w0;
    w0  = reg_we && reg_addr == 3'd0;
    req = m_gie & ((|(m_cf & m_ce)) | (m_peie & ((|(m_pf0 & m_pe0)) | (|(m_pf1 & m_pe1)))));
    clr = w0 && !reg_wdata[7];
    tk  = insn_boundary & req & !clr & !m_take;
    @(posedge clk);
    #1;
    m_cf  = (w0 ? reg_wdata[2:0] : m_cf) | core_evt;
    if (w0) m_ce = reg_wdata[5:3];
    if (w0) m_peie = reg_wdata[6];
    m_pf0 = ((reg_we && reg_addr == 3'd1) ? reg_wdata : m_pf0) | per0_evt;
    m_pf1 = ((reg_we && reg_addr == 3'd3) ? reg_wdata : m_pf1) | per1_evt;
    if (reg_we && reg_addr == 3'd2) m_pe0 = reg_wdata;
    if (reg_we && reg_addr == 3'd4) m_pe1 = reg_wdata;
    if (tk) m_gie = 0;
    else if (retfie) m_gie = 1;
    else if (w0) m_gie = reg_wdata[7];
    m_take = tk;
    chk(tag, 32'(take_irq), 32'(m_take));
    chk({tag, "/R3 push"}, 32'(push_ret), 32'(m_take));
    if (take_irq) chk("R3 vector", 32'(vector_pc), 32'h4);
    chk({tag, "/R8 read"}, 32'(reg_rdata), 32'(m_read(reg_addr)));
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, string tag);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step(tag);
    reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    reg_addr = a;
    #1;
    chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R2 reset state
    for (int a = 0; a < 5; a++) rd(3'(a), 8'h00, "R2 reset read");
    chk("R2 take after reset", 32'(take_irq), 0);

    // R1: flags latch with all enables off
    core_evt = 3'b010; step("R1"); core_evt = '0;
    rd(3'd0, 8'h02, "R1 core flag masked");
    per0_evt = 8'h08; step("R1"); per0_evt = '0;
    rd(3'd1, 8'h08, "R1 per flag masked");
    // R8: unused address
    wr(3'd5, 8'hFF, "R8"); rd(3'd5, 8'h00, "R8 unused addr");
    // R1: hardware set beats same-cycle clear
    per0_evt = 8'h01; wr(3'd1, 8'h00, "R1"); per0_evt = '0;
    rd(3'd1, 8'h01, "R1 set wins over clear");
    wr(3'd1, 8'h00, "R1"); wr(3'd0, 8'h00, "R1");

    // R7: peripheral gated by group enable
    insn_boundary = 1;
    per1_evt = 8'h20; wr(3'd4, 8'h20, "R7"); per1_evt = '0;
    wr(3'd0, 8'h80, "R7");
    step("R7"); chk("R7 group enable off", 32'(take_irq), 0);
    wr(3'd0, 8'hC0, "R7");
    step("R7"); chk("R7 group enable on", 32'(take_irq), 1);
    wr(3'd3, 8'h00, "R7"); wr(3'd0, 8'h00, "R7");

    // R9 / R3 latency and entry
    wr(3'd0, 8'h90, "R9");
    core_evt = 3'b010; step("R9"); core_evt = '0;
    chk("R9 no take at flag edge", 32'(take_irq), 0);
    rd(3'd0, 8'h92, "R9 flag set");
    step("R9"); chk("R9 take one edge later", 32'(take_irq), 1);
    chk("R3 push", 32'(push_ret), 1);
    chk("R3 vector", 32'(vector_pc), 32'h4);
    rd(3'd0, 8'h12, "R3 gie cleared");
    step("R3"); chk("R3 single pulse", 32'(take_irq), 0);

    // R4 / R6: return re-arms, pending flag retaken
    retfie = 1; step("R4"); retfie = 0;
    rd(3'd0, 8'h92, "R4 gie set");
    step("R6"); chk("R6 retaken", 32'(take_irq), 1);
    wr(3'd0, 8'h90, "R6"); step("R6");
    chk("R6 cleared flag no take", 32'(take_irq), 0);

    // R5: suppression by clearing write
    core_evt = 3'b100; wr(3'd0, 8'hA0, "R5"); core_evt = '0;
    wr(3'd0, 8'h24, "R5");
    chk("R5 suppressed", 32'(take_irq), 0);
    rd(3'd0, 8'h24, "R5 flag kept");
    wr(3'd0, 8'hA4, "R5");
    step("R5"); chk("R5 serviced later", 32'(take_irq), 1);

    // R10: boundary low blocks
    insn_boundary = 0;
    wr(3'd0, 8'hA4, "R10");
    step("R10"); chk("R10 no boundary", 32'(take_irq), 0);
    insn_boundary = 1;
    step("R10"); chk("R10 boundary high", 32'(take_irq), 1);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      core_evt      = ($urandom % 8 == 0) ? 3'($urandom) : '0;
      per0_evt      = ($urandom % 8 == 0) ? 8'(1 << ($urandom % 8)) : '0;
      per1_evt      = ($urandom % 8 == 0) ? 8'(1 << ($urandom % 8)) : '0;
      reg_addr      = 3'($urandom % 6);
      reg_we        = ($urandom % 5 == 0);
      reg_wdata     = 8'($urandom);
      insn_boundary = ($urandom % 3 != 0);
      retfie        = ($urandom % 12 == 0);
      step("R7/R1 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule